// File: doc/BRIEF.md
# Serial-Input Column-Counting Multiplier

This block multiplies two unsigned W-bit operands whose bits arrive one per clock, least significant bit first, on two serial lines. While the bits stream in, the block keeps both operands in shift registers. Each cycle a row of AND gates forms every partial-product bit that the newest pair of bits creates. Each weight column of the partial-product matrix has its own ones counter, which adds the new bits to that column's total. The whole matrix is therefore collapsed in W input cycles, and each column ends up as a count of floor(log2 W)+1 bits.

Once the last bit is in, the column counts are shifted to their weights (count k is worth 2^k). A carry-save adder array reduces them to a sum vector and a carry vector, and these are registered. A final carry-propagate addition then writes the 2W-bit product to a register, and a one-cycle done pulse goes out with it. The reduction and final-add stages are pipelined behind the counters. A new operand pair may therefore start streaming on the cycle right after the previous last bit.

Top module: `serial_colcount_mul`

## Requirements
- R1: During and right after a synchronous reset, done_o is 0 and product_o is 0.
- R2: The cycle in which start_i is 1 carries operand bit 0 on a_bit_i and b_bit_i. Bits 1 to W-1 follow on the next W-1 consecutive cycles.
- R3: Count the start cycle as cycle 0. done_o is 1 in cycle W+2 only, a single-cycle pulse for each operation that completes.
- R4: When done_o is 1, product_o equals the unsigned product a*b of the two streamed operands. This holds for zero operands, all-ones operands and every other pair.
- R5: product_o changes only in a cycle where done_o is 1. Between completions it holds the last product.
- R6: A start_i that arrives while bits of an earlier operation are still streaming abandons that operation. Only the new operation produces a done pulse.
- R7: A start_i in cycle W, right after the previous operation's last bit, is accepted. Both operations complete with correct products, and their done pulses come W cycles apart.
- R8: The count of column k never exceeds the number of bit pairs (i,j) with i+j=k, which is min(k+1, 2W-1-k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Marks the cycle carrying operand bit 0 |
| a_bit_i | input | 1 | Serial multiplicand bit, LSB first |
| b_bit_i | input | 1 | Serial multiplier bit, LSB first |
| done_o | output | 1 | One-cycle pulse when product_o is updated |
| product_o | output | 2W | Registered unsigned product |

## Verification
Two things can happen in the same cycle. The carry-save stage can capture the finished column counts of one operation on the same clock edge where a start_i clears those counters and loads bit 0 of the next. In the same way, the final add and done pulse of one operation fall inside the bit-loading window of the next. The sweep provokes both by streaming every operand pair of a small width back to back, with no gap. Each done pulse is judged against a queue of expected products and expected completion cycles computed arithmetically. A second pass with idle gaps, and an abandoned partial operation, show that a lone operation and a restart give exactly one correctly timed result.

// File: rtl/sccm_pkg.sv
package sccm_pkg;
  // number of operand bit pairs (i,j) with i+j == k for w-bit operands
  function automatic int col_pairs(input int w, input int k);
    return (k < w) ? k + 1 : 2 * w - 1 - k;
  endfunction

  // width of a column ones counter: floor(log2 w)+1
  function automatic int cnt_bits(input int w);
    return $clog2(w + 1);
  endfunction
endpackage

// File: rtl/sccm_loader.sv
module sccm_loader #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         a_bit_i,
  input  logic         b_bit_i,
  output logic         take_o,
  output logic         last_o,
  output logic [W-1:0] a_cur_o,
  output logic [W-1:0] b_cur_o,
  output logic [W-1:0] pos_oh_o
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  a_sr, b_sr;
  logic [IW-1:0] idx;
  logic          active;

  always_comb begin
    take_o   = start_i | active;
    pos_oh_o = '0;
    if (start_i)     pos_oh_o[0]   = 1'b1;
    else if (active) pos_oh_o[idx] = 1'b1;
    a_cur_o = (start_i ? '0 : a_sr) | ((a_bit_i && take_o) ? pos_oh_o : '0);
    b_cur_o = (start_i ? '0 : b_sr) | ((b_bit_i && take_o) ? pos_oh_o : '0);
    if (start_i) last_o = (W == 1);
    else         last_o = active && (idx == IW'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sr   <= '0;
      b_sr   <= '0;
      idx    <= '0;
      active <= 1'b0;
    end else begin
      if (take_o) begin
        a_sr <= a_cur_o;
        b_sr <= b_cur_o;
      end
      if (start_i) begin
        idx    <= IW'(1);
        active <= (W > 1);
      end else if (active) begin
        if (last_o) begin
          active <= 1'b0;
          idx    <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sccm_columns.sv
module sccm_columns #(
  parameter int W = 8,
  localparam int COLS = 2 * W - 1,
  localparam int CW   = sccm_pkg::cnt_bits(W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take_i,
  input  logic                     start_i,
  input  logic [W-1:0]             a_cur_i,
  input  logic [W-1:0]             b_cur_i,
  input  logic [W-1:0]             pos_oh_i,
  output logic [COLS-1:0][CW-1:0]  col_cnt_o
);
  for (genvar k = 0; k < COLS; k++) begin : g_col
    localparam int ILO = (k >= W) ? k - W + 1 : 0;
    localparam int IHI = (k < W) ? k : W - 1;
    logic [CW-1:0] inc, cnt;

    // only pairs touching the newest bit position are new this cycle
    always_comb begin
      inc = '0;
      for (int i = ILO; i <= IHI; i++)
        inc = inc + CW'(a_cur_i[i] & b_cur_i[k-i] & (pos_oh_i[i] | pos_oh_i[k-i]));
    end

    always_ff @(posedge clk) begin
      if (rst)         cnt <= '0;
      else if (take_i) cnt <= (start_i ? '0 : cnt) + inc;
    end

    assign col_cnt_o[k] = cnt;
  end
endmodule

// File: rtl/sccm_csa.sv
module sccm_csa #(
  parameter int W = 8,
  localparam int COLS = 2 * W - 1,
  localparam int CW   = sccm_pkg::cnt_bits(W),
  localparam int PW   = 2 * W
) (
  input  logic [COLS-1:0][CW-1:0] col_cnt_i,
  output logic [PW-1:0]           sum_o,
  output logic [PW-1:0]           car_o
);
  logic [PW-1:0] s, c, t, ns, nc;

  always_comb begin
    s  = '0;
    c  = '0;
    t  = '0;
    ns = '0;
    nc = '0;
    for (int k = 0; k < COLS; k++) begin
      t  = PW'(col_cnt_i[k]) << k;
      ns = s ^ c ^ t;
      nc = ((s & c) | (s & t) | (c & t)) << 1;
      s  = ns;
      c  = nc;
    end
    sum_o = s;
    car_o = c;
  end
endmodule

// File: rtl/serial_colcount_mul.sv
module serial_colcount_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           a_bit_i,
  input  logic           b_bit_i,
  output logic           done_o,
  output logic [2*W-1:0] product_o
);
  localparam int COLS = 2 * W - 1;
  localparam int CW   = sccm_pkg::cnt_bits(W);
  localparam int PW   = 2 * W;

  logic                    take, last_take;
  logic [W-1:0]            a_cur, b_cur, pos_oh;
  logic [COLS-1:0][CW-1:0] col_cnt;
  logic [PW-1:0]           csa_sum, csa_car, sum_q, car_q;
  logic                    red_v, add_v;

  sccm_loader #(.W(W)) loader_i (
    .clk(clk), .rst(rst), .start_i(start_i), .a_bit_i(a_bit_i), .b_bit_i(b_bit_i),
    .take_o(take), .last_o(last_take), .a_cur_o(a_cur), .b_cur_o(b_cur), .pos_oh_o(pos_oh)
  );

  sccm_columns #(.W(W)) cols_i (
    .clk(clk), .rst(rst), .take_i(take), .start_i(start_i),
    .a_cur_i(a_cur), .b_cur_i(b_cur), .pos_oh_i(pos_oh), .col_cnt_o(col_cnt)
  );

  sccm_csa #(.W(W)) csa_i (
    .col_cnt_i(col_cnt), .sum_o(csa_sum), .car_o(csa_car)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      red_v     <= 1'b0;
      add_v     <= 1'b0;
      sum_q     <= '0;
      car_q     <= '0;
      done_o    <= 1'b0;
      product_o <= '0;
    end else begin
      red_v  <= last_take;
      add_v  <= red_v;
      done_o <= add_v;
      if (red_v) begin
        sum_q <= csa_sum;
        car_q <= csa_car;
      end
      if (add_v) product_o <= sum_q + car_q;
    end
  end
endmodule

// File: rtl/serial_colcount_mul_chk.sv
module serial_colcount_mul_chk #(
  parameter int W = 8,
  localparam int COLS = 2 * W - 1,
  localparam int CW   = sccm_pkg::cnt_bits(W)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    done_o,
  input logic [2*W-1:0]          product_o,
  input logic                    last_take,
  input logic [COLS-1:0][CW-1:0] col_cnt
);
  logic [1:0] since_rst;
  logic       seen_edge = 1'b0;

  always_ff @(posedge clk) begin
    seen_edge <= 1'b1;
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (!done_o && product_o == '0));

  a_r3_done_timing: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (done_o == $past(last_take, 3)));

  a_r5_product_hold: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0 && !done_o) |-> $stable(product_o));

  for (genvar k = 0; k < COLS; k++) begin : g_bound
    a_r8_col_bound: assert property (@(posedge clk) disable iff (rst)
      col_cnt[k] <= CW'(sccm_pkg::col_pairs(W, k)));
  end
endmodule

bind serial_colcount_mul serial_colcount_mul_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .done_o(done_o), .product_o(product_o),
  .last_take(last_take), .col_cnt(col_cnt)
);

// File: tb/serial_colcount_mul_tb_top.sv
module serial_colcount_mul_tb_top;
  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0, a_bit_i = 1'b0, b_bit_i = 1'b0;
  logic          done_o;
  logic [PW-1:0] product_o;

  int total = 0, bad = 0, cyc = 0;
  logic [PW-1:0] exp_prod[$];
  int            exp_cyc[$];
  logic [PW-1:0] last_prod = '0;

  always #2 clk = ~clk;

  serial_colcount_mul #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .a_bit_i(a_bit_i),
    .b_bit_i(b_bit_i), .done_o(done_o), .product_o(product_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) if (cyc > 150000) begin
    total++; bad++;
    $display("FAIL watchdog: cycle %0d reached, expected end before 150000", cyc);
    report_end();
  end

  // monitor: every done pulse must match the next expected product and cycle
  always @(negedge clk) if (!rst && done_o) begin
    total++;
    if (exp_prod.size() == 0) begin
      bad++;
      $display("FAIL R6/R3: unexpected done at cycle %0d, product=%0d, expected no done", cyc, product_o);
    end else begin
      logic [PW-1:0] ep;
      int ec;
      ep = exp_prod.pop_front();
      ec = exp_cyc.pop_front();
      if (product_o !== ep) begin
        bad++;
        $display("FAIL R4: product=%0d expected=%0d", product_o, ep);
      end
      total++;
      if (cyc != ec) begin
        bad++;
        $display("FAIL R3/R7: done at cycle %0d expected cycle %0d", cyc, ec);
      end
      last_prod = product_o;
    end
  end

  // drive one operation; called at a negedge, returns at a negedge
  task automatic send_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit expect_it);
    if (expect_it) begin
      exp_prod.push_back(PW'(a) * PW'(b));
      exp_cyc.push_back(cyc + W + 2);
    end
    for (int t = 0; t < W; t++) begin
      start_i = (t == 0);
      a_bit_i = a[t];
      b_bit_i = b[t];
      @(negedge clk);
    end
    start_i = 1'b0;
    a_bit_i = 1'b0;
    b_bit_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_hold(input string tag);
    total++;
    if (done_o !== 1'b0 || product_o !== last_prod) begin
      bad++;
      $display("FAIL %s: done=%0b product=%0d expected done=0 product=%0d", tag, done_o, product_o, last_prod);
    end
  endtask

  initial begin
    idle(3);
    // R1: reset state
    total++;
    if (done_o !== 1'b0 || product_o !== '0) begin
      bad++;
      $display("FAIL R1: done=%0b product=%0d expected 0/0", done_o, product_o);
    end
    rst = 1'b0;
    idle(2);
    total++;
    if (done_o !== 1'b0 || product_o !== '0) begin
      bad++;
      $display("FAIL R1: after reset done=%0b product=%0d expected 0/0", done_o, product_o);
    end

    // R4 corners with gaps (R2 framing, R3 timing for a lone operation)
    send_op('0, '0, 1);              idle(6); check_hold("R5");
    send_op('1, '1, 1);              idle(6); check_hold("R5");
    send_op('1, '0, 1);              idle(6); check_hold("R5");
    send_op(W'(1), '1, 1);           idle(6); check_hold("R5");
    send_op(W'(1) << (W-1), W'(1) << (W-1), 1); idle(6);

    // R6: abandoned partial operation, then a fresh one
    start_i = 1'b1; a_bit_i = 1'b1; b_bit_i = 1'b1; @(negedge clk);
    start_i = 1'b0; @(negedge clk); @(negedge clk);
    send_op(W'(5), W'(3), 1);        idle(8); check_hold("R6");

    // start one cycle late (cycle W+1 of previous)
    send_op(W'(45), W'(27), 1); idle(1);
    send_op(W'(63), W'(62), 1); idle(8);

    // R7 + R4: exhaustive back-to-back sweep
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        send_op(W'(a), W'(b), 1);
    idle(10);

    // R5: product held after the last completion
    check_hold("R5");
    idle(5);
    check_hold("R5");

    // R3/R6: every expected completion seen
    total++;
    if (exp_prod.size() != 0) begin
      bad++;
      $display("FAIL R3: %0d completions missing, expected 0", exp_prod.size());
    end
    report_end();
  end
endmodule